// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns an asynchronous serial line into 8-bit characters. It runs from a base-rate tick that pulses at sixteen times the bit rate. It finds each frame from the falling edge of its start bit. It can check an optional even or odd parity bit, and it checks one stop bit. Each finished character goes into a holding register, and a receive-full flag is raised. Software consumes the character by pulsing a clear strobe.

Three error conditions are held in sticky flags: a bad stop bit, a parity mismatch, and a character that arrived while the previous one was still unread. Software clears each flag with its own one-cycle strobe. The receive enable only gates the receiver; it never clears a flag.

If the line is held low (a break), the receiver keeps running. Every all-zero frame raises the stop-bit error again, even after software has cleared it. The synchronised line level is always available on an output, so software can tell a break from a single bad frame.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, the data register is 0. The full flag and all three error flags are 0, and the line-level output is 1.
- R2: With the receiver enabled, a low line seen on a base tick starts a frame. The start bit is re-checked on the 8th tick after detection. Each later bit is sampled 16 ticks after the one before, with data sent LSB first. A finished frame loads the data register and sets the full flag.
- R3: When parity is enabled (par_en_i=1), one parity bit follows the 8 data bits. With par_odd_i=0 the count of ones over data and parity must be even; with par_odd_i=1 it must be odd. A mismatch sets parity_err_o.
- R4: A stop bit sampled as 0 sets frame_err_o. The received data is still loaded and the full flag is still set.
- R5: A frame that finishes while the full flag is set (and is not being cleared in that cycle) sets overrun_o. The new data is thrown away, the data register keeps the old character, and the stop-bit and parity flags are not updated.
- R6: Each flag stays set until its own clear strobe is pulsed: clr_full_i, clr_frame_i, clr_parity_i or clr_overrun_i. If a new set and a clear fall in the same cycle, the set wins.
- R7: While rx_en_i is 0, the receiver stays idle and accepts no frames. The data register and all flags keep their values.
- R8: While the line is held low, frames keep completing one after another. A cleared frame_err_o is set again by the next all-zero frame, and line_level_o reads 0.
- R9: If the start bit is high again at its mid-bit check, it is treated as noise. The receiver returns to idle and loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Base tick at 16x the bit rate, one clock wide |
| rx_en_i | input | 1 | Receiver enable |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| clr_full_i | input | 1 | Clear strobe for the full flag |
| clr_frame_i | input | 1 | Clear strobe for the stop-bit error flag |
| clr_parity_i | input | 1 | Clear strobe for the parity error flag |
| clr_overrun_i | input | 1 | Clear strobe for the overrun flag |
| rx_data_o | output | 8 | Last accepted character |
| rx_full_o | output | 1 | Character waiting to be read |
| frame_err_o | output | 1 | Sticky stop-bit error |
| parity_err_o | output | 1 | Sticky parity error |
| overrun_o | output | 1 | Sticky overrun |
| line_level_o | output | 1 | Synchronised line level |

## Verification
The properties assume three things about the inputs:
- The base tick is a single-clock pulse.
- The clear strobes are single-clock pulses driven by software.
- The serial line changes only in step with the tick cadence.

The bench derives the tick from a fixed clock divider. It changes rxd_i just after a tick edge and holds each bit for exactly sixteen ticks, so every mid-bit sample lands well inside the bit. Clears are driven for one clock between negative edges, so they never overlap a frame completion unless a test intends that.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic full;
        logic frame_err;
        logic parity_err;
        logic overrun;
    } rx_flags_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              stop_bad_o,
    output logic              par_bad_o,
    output rx_state_e         state_o
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] shift;
        logic              par_acc;
        logic              use_par;
    } fsm_t;

    fsm_t d, q;
    logic done_c, stop_bad_c, par_bad_c;

    always_comb begin
        d          = q;
        done_c     = 1'b0;
        stop_bad_c = 1'b0;
        par_bad_c  = 1'b0;
        if (!rx_en) begin
            d.state = ST_IDLE;
            d.cnt   = '0;
        end else if (tick) begin
            unique case (q.state)
                ST_IDLE: begin
                    if (!rxd) begin
                        d.state = ST_START;
                        d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (q.cnt == MID_CNT) begin
                        d.cnt = '0;
                        if (rxd) begin
                            d.state = ST_IDLE;
                        end else begin
                            d.state   = ST_DATA;
                            d.bitn    = '0;
                            d.par_acc = 1'b0;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (q.cnt == LAST_CNT) begin
                        d.cnt     = '0;
                        d.shift   = {rxd, q.shift[DATA_W-1:1]};
                        d.par_acc = q.par_acc ^ rxd;
                        if (q.bitn == LAST_BIT) begin
                            d.use_par = par_en;
                            d.state   = par_en ? ST_PAR : ST_STOP;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (q.cnt == LAST_CNT) begin
                        d.cnt     = '0;
                        d.par_acc = q.par_acc ^ rxd;
                        d.state   = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q.cnt == LAST_CNT) begin
                        d.cnt      = '0;
                        d.state    = ST_IDLE;
                        done_c     = 1'b1;
                        stop_bad_c = ~rxd;
                        par_bad_c  = q.use_par & (q.par_acc != par_odd);
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.cnt     <= '0;
            q.bitn    <= '0;
            q.shift   <= '0;
            q.par_acc <= 1'b0;
            q.use_par <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign done_o     = done_c;
    assign data_o     = q.shift;
    assign stop_bad_o = stop_bad_c;
    assign par_bad_o  = par_bad_c;
    assign state_o    = q.state;
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              stop_bad,
    input  logic              par_bad,
    input  logic              clr_full,
    input  logic              clr_frame,
    input  logic              clr_parity,
    input  logic              clr_overrun,
    output logic [DATA_W-1:0] data_o,
    output rx_flags_t         flags_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        rx_flags_t         fl;
    } hold_t;

    hold_t d, q;

    always_comb begin
        d = q;
        if (clr_full)    d.fl.full       = 1'b0;
        if (clr_frame)   d.fl.frame_err  = 1'b0;
        if (clr_parity)  d.fl.parity_err = 1'b0;
        if (clr_overrun) d.fl.overrun    = 1'b0;
        if (done) begin
            if (q.fl.full && !clr_full) begin
                d.fl.overrun = 1'b1;
            end else begin
                d.data    = data;
                d.fl.full = 1'b1;
                if (stop_bad) d.fl.frame_err  = 1'b1;
                if (par_bad)  d.fl.parity_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o  = q.data;
    assign flags_o = q.fl;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              tick_i,
    input  logic              rx_en_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              clr_full_i,
    input  logic              clr_frame_i,
    input  logic              clr_parity_i,
    input  logic              clr_overrun_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_full_o,
    output logic              frame_err_o,
    output logic              parity_err_o,
    output logic              overrun_o,
    output logic              line_level_o
);
    logic              rxd_s;
    logic              fr_done;
    logic [DATA_W-1:0] fr_data;
    logic              fr_stop_bad;
    logic              fr_par_bad;
    rx_state_e         fr_state;
    rx_flags_t         flags;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd_i),
        .dout (rxd_s)
    );

    uart_rx_fsm #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_i),
        .rx_en     (rx_en_i),
        .par_en    (par_en_i),
        .par_odd   (par_odd_i),
        .rxd       (rxd_s),
        .done_o    (fr_done),
        .data_o    (fr_data),
        .stop_bad_o(fr_stop_bad),
        .par_bad_o (fr_par_bad),
        .state_o   (fr_state)
    );

    uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (fr_done),
        .data       (fr_data),
        .stop_bad   (fr_stop_bad),
        .par_bad    (fr_par_bad),
        .clr_full   (clr_full_i),
        .clr_frame  (clr_frame_i),
        .clr_parity (clr_parity_i),
        .clr_overrun(clr_overrun_i),
        .data_o     (rx_data_o),
        .flags_o    (flags)
    );

    assign rx_full_o    = flags.full;
    assign frame_err_o  = flags.frame_err;
    assign parity_err_o = flags.parity_err;
    assign overrun_o    = flags.overrun;
    assign line_level_o = rxd_s;
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              clr_full,
    input logic              clr_frame,
    input logic              clr_parity,
    input logic              clr_overrun,
    input logic              done,
    input rx_state_e         state,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              frame_err,
    input logic              parity_err,
    input logic              overrun
);
    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state == ST_IDLE);

    assert_data_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !clr_full |=> $stable(rx_data));

    assert_frame_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err && !clr_frame |=> frame_err);

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !clr_overrun |=> overrun);

    assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_overrun && !done |=> !overrun);

    assert_frame_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_err && !done |=> !frame_err);

    assert_parity_only_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_err && !done |=> !parity_err);

    assert_full_only_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_full && !done |=> !rx_full);
endmodule

bind uart_rx_core uart_rx_checker #(.DATA_W(DATA_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en_i),
    .clr_full   (clr_full_i),
    .clr_frame  (clr_frame_i),
    .clr_parity (clr_parity_i),
    .clr_overrun(clr_overrun_i),
    .done       (fr_done),
    .state      (fr_state),
    .rx_data    (rx_data_o),
    .rx_full    (rx_full_o),
    .frame_err  (frame_err_o),
    .parity_err (parity_err_o),
    .overrun    (overrun_o)
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] div = 2'd0;
    logic       rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic       clr_full = 1'b0, clr_frame = 1'b0, clr_parity = 1'b0, clr_overrun = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, frame_err, parity_err, overrun, line_level;
    int         n_checks = 0;
    int         n_errors = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        div  <= div + 2'd1;
        tick <= (div == 2'd3);
    end

    uart_rx_core u_dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick_i(tick),
        .rx_en_i(rx_en), .par_en_i(par_en), .par_odd_i(par_odd),
        .clr_full_i(clr_full), .clr_frame_i(clr_frame),
        .clr_parity_i(clr_parity), .clr_overrun_i(clr_overrun),
        .rx_data_o(rx_data), .rx_full_o(rx_full), .frame_err_o(frame_err),
        .parity_err_o(parity_err), .overrun_o(overrun), .line_level_o(line_level)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
        #1;
    endtask

    task automatic sample_point();
        @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: clr_full    = 1'b1;
            1: clr_frame   = 1'b1;
            2: clr_parity  = 1'b1;
            default: clr_overrun = 1'b1;
        endcase
        @(negedge clk);
        clr_full = 1'b0; clr_frame = 1'b0; clr_parity = 1'b0; clr_overrun = 1'b0;
    endtask

    task automatic clear_all();
        for (int k = 0; k < 4; k++) pulse(k);
    endtask

    task automatic send_frame(input logic [7:0] data, input logic pbit, input logic stop);
        wait_ticks(1);
        rxd = 1'b0;
        wait_ticks(16);
        for (int b = 0; b < 8; b++) begin
            rxd = data[b];
            wait_ticks(16);
        end
        if (par_en) begin
            rxd = pbit;
            wait_ticks(16);
        end
        rxd = stop;
        wait_ticks(16);
        rxd = 1'b1;
        wait_ticks(6);
        sample_point();
    endtask

    task automatic t_reset();
        sample_point();
        check("R1 data", rx_data, 0);
        check("R1 full", rx_full, 0);
        check("R1 frame", frame_err, 0);
        check("R1 parity", parity_err, 0);
        check("R1 overrun", overrun, 0);
        check("R1 level", line_level, 1);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 1'b0, 1'b1);
        check("R2 data A5", rx_data, 8'hA5);
        check("R2 full", rx_full, 1);
        check("R2 no frame err", frame_err, 0);
        pulse(0);
        sample_point();
        check("R6 full cleared", rx_full, 0);
        send_frame(8'h3C, 1'b0, 1'b1);
        check("R2 data 3C", rx_data, 8'h3C);
        pulse(0);
    endtask

    task automatic t_parity();
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h17, ^8'h17, 1'b1);
        check("R3 even ok data", rx_data, 8'h17);
        check("R3 even ok", parity_err, 0);
        pulse(0);
        send_frame(8'h17, ~(^8'h17), 1'b1);
        check("R3 even bad", parity_err, 1);
        pulse(0); pulse(2);
        par_odd = 1'b1;
        send_frame(8'hC3, ~(^8'hC3), 1'b1);
        check("R3 odd ok", parity_err, 0);
        check("R3 odd data", rx_data, 8'hC3);
        pulse(0);
        send_frame(8'hC3, ^8'hC3, 1'b1);
        check("R3 odd bad", parity_err, 1);
        clear_all();
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'h81, 1'b0, 1'b0);
        check("R4 frame err", frame_err, 1);
        check("R4 data loaded", rx_data, 8'h81);
        check("R4 full", rx_full, 1);
        wait_ticks(40);
        sample_point();
        check("R6 frame sticky", frame_err, 1);
        pulse(1);
        sample_point();
        check("R6 frame cleared", frame_err, 0);
        pulse(0);
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 1'b0, 1'b1);
        send_frame(8'h22, 1'b0, 1'b0);
        check("R5 overrun", overrun, 1);
        check("R5 data kept", rx_data, 8'h11);
        check("R5 frame not updated", frame_err, 0);
        pulse(3);
        sample_point();
        check("R6 overrun cleared", overrun, 0);
        pulse(0);
    endtask

    task automatic t_disable();
        send_frame(8'h66, 1'b0, 1'b0);
        rx_en = 1'b0;
        wait_ticks(4);
        sample_point();
        check("R7 frame kept", frame_err, 1);
        check("R7 full kept", rx_full, 1);
        pulse(0);
        send_frame(8'h99, 1'b0, 1'b1);
        check("R7 no frame accepted", rx_full, 0);
        check("R7 data unchanged", rx_data, 8'h66);
        check("R7 frame still set", frame_err, 1);
        rx_en = 1'b1;
        pulse(1);
    endtask

    task automatic t_break();
        par_en = 1'b1; par_odd = 1'b1;
        wait_ticks(1);
        rxd = 1'b0;
        wait_ticks(180);
        sample_point();
        check("R8 level low", line_level, 0);
        check("R8 frame err", frame_err, 1);
        check("R8 parity err", parity_err, 1);
        check("R8 data zero", rx_data, 0);
        pulse(0); pulse(1);
        sample_point();
        check("R8 frame cleared", frame_err, 0);
        wait_ticks(170);
        sample_point();
        check("R8 frame reasserted", frame_err, 1);
        check("R8 full again", rx_full, 1);
        rxd = 1'b1;
        wait_ticks(200);
        sample_point();
        check("R8 level high", line_level, 1);
        clear_all();
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_noise();
        wait_ticks(1);
        rxd = 1'b0;
        wait_ticks(3);
        rxd = 1'b1;
        wait_ticks(200);
        sample_point();
        check("R9 noise ignored", rx_full, 0);
        send_frame(8'h5A, 1'b0, 1'b1);
        check("R9 next frame ok", rx_data, 8'h5A);
        pulse(0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        t_basic();
        t_parity();
        t_framing();
        t_overrun();
        t_disable();
        t_break();
        t_noise();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule